// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block moves data between locations of a 20-bit byte address space on behalf of two independent channels. Every accepted request moves exactly one unit, either a byte or a 16-bit half-word. The engine first asks for the bus, waits for the grant, reads one unit from the source address and then writes it to the destination address. Only one bus cycle pair is taken per request, so the processor keeps the bus between units.

Each channel holds a source address, a destination address, a 16-bit down-counter, a reload value for that counter and a control word. At most one of the two addresses may step after each unit. The other address stays fixed, and fixed-to-fixed copies are also allowed. Turning a channel on copies the stepping address into a private working pointer and copies the reload value into the counter. The counter counts down once per unit. When it wraps below zero, the channel raises a one-cycle interrupt pulse. In single mode the channel then turns itself off. In repeat mode the channel refills the counter from the reload value and keeps running.

Requests come from a per-channel software pulse, and from an external line that each channel can watch for falling edges or for both edges. The memory side is a valid/ready interface. A beat moves on a rising clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the engine holds the address, direction, width and write data steady and keeps `mem_valid` asserted. `mem_rdata` is sampled in the same cycle that a read beat is accepted.

Top module: `dma2ch_core`

## Requirements
- R1: Configuration is written through `cfg_we`, with `cfg_ch` selecting the channel and `cfg_reg` selecting the target: 0 source address, 1 destination address, 2 counter reload (low 16 bits), 3 control. The control bits are: [0] enable, [1] 16-bit unit, [2] repeat mode, [3] source steps, [4] destination steps, [6:5] trigger mode. `ch_en` shows the enable bit of each channel, and it is 0 after reset.
- R2: A control write that sets both step bits is ignored completely. The previous control word, including its enable bit, stays in force.
- R3: A control write that turns the enable bit from 0 to 1 loads the working pointer from the address chosen by the new step bits (the destination if only the destination steps, otherwise the source) and loads the counter from the reload value.
- R4: Each request seen while the channel is enabled causes exactly one read from the source address, followed by one write of the same data to the destination address. For 8-bit units only `mem_wdata[7:0]` carries data. Requests seen while the channel is disabled are dropped.
- R5: When both channels have a request waiting at arbitration, channel 0 is served first.
- R6: After each unit, the stepping address advances by 1 for 8-bit units or by 2 for 16-bit units. A fixed address never changes.
- R7: A counter loaded with N allows N+1 units. After the last of these units, `irq` pulses for one cycle. In single mode the enable bit clears at that same edge, and later requests are dropped.
- R8: In repeat mode, an underflow refills the counter from the reload value and pulses `irq`. The channel stays enabled and the working pointer keeps advancing.
- R9: Trigger mode 0 accepts only the software pulse. Mode 1 also accepts a falling edge on `ext_line`. Mode 2 also accepts either edge. A rising edge in mode 1 is not a request.
- R10: `bus_req` rises before any beat and stays high until the write beat is accepted. No beat is offered before `bus_gnt` has been seen. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold their values.
- R11: Any number of requests arriving for a channel after its current unit has been picked collapse into one further unit.
- R12: Clearing the enable bit stops the channel and discards a request it already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_reg | input | 2 | Target register of the write |
| cfg_wdata | input | 20 | Write data |
| sw_trig | input | 2 | Software request pulse, one bit per channel |
| ext_line | input | 2 | External request line, one bit per channel |
| ch_en | output | 2 | Enable bit of each channel |
| irq | output | 2 | One-cycle underflow pulse, one bit per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_valid | output | 1 | Beat offered on the memory side |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_wide | output | 1 | 1 for a 16-bit unit |
| mem_addr | output | 20 | Byte address of the beat |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, sampled when a read beat is accepted |

## Verification
A corrupted working pointer shows up on `mem_addr` during the very next read or write beat, as a run of addresses that breaks the +1 or +2 step. A fixed address that drifts shows up the same way. A counter that is off by even one unit moves the `irq` pulse and the fall of `ch_en` by a whole unit, and this becomes visible at the end of the first run. A wrong pending flag or a wrong arbitration choice shows up as a missing or extra read beat, or as the wrong channel's address on the first beat after a shared request. The checks therefore count beats and compare addresses and write data beat by beat.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_RLD = 2'd2,
    SEL_CTL = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_FALL = 2'd1,
    TRG_BOTH = 2'd2,
    TRG_RSVD = 2'd3
  } trig_e;

  // control word, LSB first: en, wide, rpt, sadv, dadv, trig[1:0]
  typedef struct packed {
    trig_e trig;
    logic  dadv;
    logic  sadv;
    logic  rpt;
    logic  wide;
    logic  en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_REQ  = 2'd1,
    BS_RD   = 2'd2,
    BS_WR   = 2'd3
  } bus_st_e;

endpackage

// File: rtl/dma2_trig.sv
module dma2_trig
  import dma2_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e mode,
  input  logic  sw,
  input  logic  line,
  output logic  evt
);

  logic prev_q;
  logic ext_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line;
  end

  always_comb begin
    case (mode)
      TRG_FALL: ext_hit = prev_q & ~line;
      TRG_BOTH: ext_hit = prev_q ^ line;
      default:  ext_hit = 1'b0;
    endcase
  end

  assign evt = sw | ext_hit;

endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cfg_sel_e          wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              evt,
  input  logic              take,
  input  logic              done,
  output logic              pend,
  output logic              en,
  output logic              wide,
  output logic              rpt,
  output logic              sadv,
  output logic              dadv,
  output trig_e             trig,
  output logic [ADDR_W-1:0] src_eff,
  output logic [ADDR_W-1:0] dst_eff,
  output logic              irq
);

  logic [ADDR_W-1:0] src_q, dst_q, fwd_q;
  logic [CNT_W-1:0]  cnt_q, rld_q;
  ctl_t              ctl_q;
  ctl_t              ctl_new;
  logic              pend_q, irq_q;
  logic              ctl_ok, ctl_wr, start, uf;
  logic [ADDR_W-1:0] step;

  assign ctl_new = ctl_t'(wr_data[CTL_W-1:0]);
  assign ctl_ok  = !(ctl_new.sadv && ctl_new.dadv);
  assign ctl_wr  = wr_en && (wr_sel == SEL_CTL) && ctl_ok;
  assign start   = ctl_wr && ctl_new.en && !ctl_q.en;
  assign uf      = (cnt_q == '0);
  assign step    = ADDR_W'(ctl_q.wide ? 2 : 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      fwd_q  <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      ctl_q  <= ctl_t'('0);
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done && uf;
      if (wr_en && wr_sel == SEL_SRC) src_q <= wr_data;
      if (wr_en && wr_sel == SEL_DST) dst_q <= wr_data;
      if (wr_en && wr_sel == SEL_RLD) rld_q <= wr_data[CNT_W-1:0];
      if (ctl_wr)
        ctl_q <= ctl_new;
      else if (done && uf && !ctl_q.rpt)
        ctl_q.en <= 1'b0;
      if (start) begin
        fwd_q <= ctl_new.dadv ? dst_q : src_q;
        cnt_q <= rld_q;
      end else if (done) begin
        if (ctl_q.sadv || ctl_q.dadv) fwd_q <= fwd_q + step;
        if (uf) cnt_q <= ctl_q.rpt ? rld_q : '1;
        else    cnt_q <= cnt_q - 1'b1;
      end
      if (!ctl_q.en)  pend_q <= 1'b0;
      else if (evt)   pend_q <= 1'b1;
      else if (take)  pend_q <= 1'b0;
    end
  end

  assign pend    = pend_q & ctl_q.en;
  assign en      = ctl_q.en;
  assign wide    = ctl_q.wide;
  assign rpt     = ctl_q.rpt;
  assign sadv    = ctl_q.sadv;
  assign dadv    = ctl_q.dadv;
  assign trig    = ctl_q.trig;
  assign src_eff = ctl_q.sadv ? fwd_q : src_q;
  assign dst_eff = ctl_q.dadv ? fwd_q : dst_q;
  assign irq     = irq_q;

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic [NCH-1:0]  pend,
  output logic [NCH-1:0]  pick_oh,
  output logic [CH_W-1:0] pick_idx,
  output logic            any
);

  // lowest index wins: the loop runs downward so the last hit is the lowest
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
        pick_idx   = CH_W'(i);
      end
    end
  end

  assign any = |pend;

endmodule

// File: rtl/dma2_bus.sv
module dma2_bus
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NCH    = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CH_W-1:0]   pick_idx,
  input  logic [ADDR_W-1:0] pick_src,
  input  logic [ADDR_W-1:0] pick_dst,
  input  logic              pick_wide,
  output logic              take,
  output logic [NCH-1:0]    done_oh,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  bus_st_e           st_q;
  logic [CH_W-1:0]   ch_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              wide_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_fin;

  assign take   = (st_q == BS_IDLE) && any;
  assign wr_fin = (st_q == BS_WR) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      wide_q <= 1'b0;
      data_q <= '0;
    end else begin
      case (st_q)
        BS_IDLE: if (any) begin
          ch_q   <= pick_idx;
          src_q  <= pick_src;
          dst_q  <= pick_dst;
          wide_q <= pick_wide;
          st_q   <= BS_REQ;
        end
        BS_REQ: if (bus_gnt) st_q <= BS_RD;
        BS_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st_q   <= BS_WR;
        end
        BS_WR: if (mem_ready) st_q <= BS_IDLE;
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_done
    assign done_oh[i] = wr_fin && (ch_q == CH_W'(i));
  end

  assign bus_req   = (st_q != BS_IDLE);
  assign mem_valid = (st_q == BS_RD) || (st_q == BS_WR);
  assign mem_write = (st_q == BS_WR);
  assign mem_wide  = wide_q;
  assign mem_addr  = (st_q == BS_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

endmodule

// File: rtl/dma2ch_core.sv
module dma2ch_core
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_reg,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]    sw_trig,
  input  logic [NCH-1:0]    ext_line,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [NCH-1:0]    evt_v, pend_v, take_v, done_v;
  logic [NCH-1:0]    wide_v, rpt_v, sadv_v, dadv_v;
  logic [ADDR_W-1:0] src_a [NCH];
  logic [ADDR_W-1:0] dst_a [NCH];
  trig_e             trig_a [NCH];
  logic [NCH-1:0]    pick_oh;
  logic [CH_W-1:0]   pick_idx;
  logic              any, take;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma2_trig u_trig (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (trig_a[i]),
      .sw   (sw_trig[i]),
      .line (ext_line[i]),
      .evt  (evt_v[i])
    );

    dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (cfg_ch == CH_W'(i))),
      .wr_sel (cfg_sel_e'(cfg_reg)),
      .wr_data(cfg_wdata),
      .evt    (evt_v[i]),
      .take   (take_v[i]),
      .done   (done_v[i]),
      .pend   (pend_v[i]),
      .en     (ch_en[i]),
      .wide   (wide_v[i]),
      .rpt    (rpt_v[i]),
      .sadv   (sadv_v[i]),
      .dadv   (dadv_v[i]),
      .trig   (trig_a[i]),
      .src_eff(src_a[i]),
      .dst_eff(dst_a[i]),
      .irq    (irq[i])
    );
  end

  dma2_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .pend    (pend_v),
    .pick_oh (pick_oh),
    .pick_idx(pick_idx),
    .any     (any)
  );

  assign take_v = pick_oh & {NCH{take}};

  dma2_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .CH_W(CH_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .any      (any),
    .pick_idx (pick_idx),
    .pick_src (src_a[pick_idx]),
    .pick_dst (dst_a[pick_idx]),
    .pick_wide(wide_v[pick_idx]),
    .take     (take),
    .done_oh  (done_v),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_write(mem_write),
    .mem_wide (mem_wide),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/dma2_chk.sv
module dma2_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    rpt,
  input logic [NCH-1:0]    sadv,
  input logic [NCH-1:0]    dadv,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sadv & dadv) == '0); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write) |=> (mem_valid && mem_write)); // R4

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq)); // R7

  AST_BEAT_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req); // R10

  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(bus_gnt)); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata))); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_SINGLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !rpt[i]) |-> !ch_en[i]); // R7
  end

endmodule

bind dma2ch_core dma2_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_en    (ch_en),
  .irq      (irq),
  .rpt      (rpt_v),
  .sadv     (sadv_v),
  .dadv     (dadv_v),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_write(mem_write),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/dma2ch_core_test.sv
module dma2ch_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic [1:0]  cfg_reg = '0;
  logic [19:0] cfg_wdata = '0;
  logic [1:0]  sw_trig = '0;
  logic [1:0]  ext_line = '0;
  logic [1:0]  ch_en, irq;
  logic        bus_req, bus_gnt, mem_valid, mem_ready, mem_write, mem_wide;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic gnt_en = 1'b1;
  logic stall = 1'b0;
  logic tick = 1'b0;
  logic breq_q = 1'b0;

  int n_chk = 0, n_err = 0;
  int n_rd = 0, n_wr = 0, n_irq0 = 0, n_irq1 = 0;
  logic [19:0] rd_a [64];
  logic [19:0] wr_a [64];
  logic [15:0] wr_d [64];

  always #10 clk = ~clk;

  dma2ch_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .sw_trig(sw_trig), .ext_line(ext_line), .ch_en(ch_en),
    .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    tick   <= ~tick;
    breq_q <= bus_req;
  end

  assign bus_gnt   = gnt_en & breq_q & bus_req;
  assign mem_ready = stall ? tick : 1'b1;
  assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (!mem_write) begin
          rd_a[n_rd[5:0]] = mem_addr;
          n_rd++;
        end else begin
          wr_a[n_wr[5:0]] = mem_addr;
          wr_d[n_wr[5:0]] = mem_wdata;
          n_wr++;
        end
      end
      if (irq[0]) n_irq0++;
      if (irq[1]) n_irq1++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    n_rd = 0; n_wr = 0; n_irq0 = 0; n_irq1 = 0;
  endtask

  task automatic cfg(input int ch, input int sel, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_reg = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctlw(input int ch, input bit en, input bit wide, input bit rpt,
                      input bit sadv, input bit dadv, input logic [1:0] trig);
    cfg(ch, 3, {13'd0, trig, dadv, sadv, rpt, wide, en});
  endtask

  task automatic fire(input logic [1:0] m);
    @(negedge clk); sw_trig = m;
    @(negedge clk); sw_trig = 2'b00;
  endtask

  task automatic check_data(input string tag, input bit wide);
    int bad = 0;
    for (int k = 0; k < n_wr; k++) begin
      logic [15:0] e;
      e = rd_a[k][15:0] ^ 16'h5A3C;
      if (wide ? (wr_d[k] !== e) : (wr_d[k][7:0] !== e[7:0])) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset bus_req", bus_req, 0);
    chk("R10 reset mem_valid", mem_valid, 0);
    chk("R7 reset irq", irq, 0);
    chk("R1 reset ch_en", ch_en, 0);
  endtask

  task automatic t_single();
    clear_log();
    cfg(0, 0, 20'h12340); cfg(0, 1, 20'h0ABC0); cfg(0, 2, 20'd2);
    fire(2'b01); idle(10);
    chk("R4 disabled request dropped", n_rd, 0);
    ctlw(0, 1, 0, 0, 1, 0, 2'd0);
    chk("R1 enable visible", ch_en[0], 1);
    fire(2'b01); idle(10);
    fire(2'b01); idle(10);
    chk("R7 no irq before underflow", n_irq0, 0);
    fire(2'b01); idle(10);
    chk("R4 one read per request", n_rd, 3);
    chk("R3 first read at source", rd_a[0], 20'h12340);
    chk("R6 byte step", rd_a[2], 20'h12342);
    chk("R6 fixed destination", wr_a[2], 20'h0ABC0);
    chk("R7 irq at underflow", n_irq0, 1);
    chk("R7 single clears enable", ch_en[0], 0);
    check_data("R4 data copied", 0);
    fire(2'b01); idle(10);
    chk("R7 stopped after underflow", n_rd, 3);
  endtask

  task automatic t_wide();
    clear_log();
    stall = 1'b1;
    cfg(1, 0, 20'h00800); cfg(1, 1, 20'h40000); cfg(1, 2, 20'd1);
    ctlw(1, 1, 1, 0, 0, 1, 2'd0);
    fire(2'b10); idle(20);
    fire(2'b10); idle(20);
    stall = 1'b0;
    chk("R10 two units under stall", n_wr, 2);
    chk("R3 pointer from destination", wr_a[0], 20'h40000);
    chk("R6 half-word step", wr_a[1], 20'h40002);
    chk("R6 fixed source", rd_a[1], 20'h00800);
    check_data("R4 16-bit data", 1);
    chk("R7 single stop ch1", ch_en[1], 0);
  endtask

  task automatic t_repeat();
    clear_log();
    cfg(1, 0, 20'h00100); cfg(1, 1, 20'h00200); cfg(1, 2, 20'd1);
    ctlw(1, 1, 0, 1, 1, 0, 2'd0);
    for (int k = 0; k < 5; k++) begin
      fire(2'b10); idle(10);
    end
    chk("R8 irq per underflow", n_irq1, 2);
    chk("R8 stays enabled", ch_en[1], 1);
    chk("R8 pointer keeps going", rd_a[4], 20'h00104);
    ctlw(1, 0, 0, 1, 1, 0, 2'd0);
    chk("R12 software stop", ch_en[1], 0);
    fire(2'b10); idle(10);
    chk("R12 no transfer after stop", n_rd, 5);
  endtask

  task automatic t_priority();
    clear_log();
    cfg(0, 0, 20'h01000); cfg(0, 1, 20'h02000); cfg(0, 2, 20'd5);
    ctlw(0, 1, 0, 0, 1, 0, 2'd0);
    cfg(1, 0, 20'h03000); cfg(1, 1, 20'h04000); cfg(1, 2, 20'd5);
    ctlw(1, 1, 0, 0, 1, 0, 2'd0);
    fire(2'b11); idle(20);
    chk("R5 both served", n_rd, 2);
    chk("R5 channel 0 first", rd_a[0], 20'h01000);
    chk("R5 channel 1 second", rd_a[1], 20'h03000);
  endtask

  task automatic t_collapse();
    clear_log();
    gnt_en = 1'b0;
    fire(2'b01); idle(3);
    fire(2'b01); fire(2'b01); fire(2'b01);
    gnt_en = 1'b1;
    idle(20);
    chk("R11 burst collapses to one", n_rd, 2);
    chk("R11 address continues", rd_a[1], 20'h01002);
    clear_log();
    gnt_en = 1'b0;
    fire(2'b01); idle(3);
    fire(2'b10);
    ctlw(1, 0, 0, 0, 1, 0, 2'd0);
    gnt_en = 1'b1;
    idle(20);
    chk("R12 held request discarded", n_rd, 1);
    chk("R12 only channel 0 ran", rd_a[0], 20'h01003);
    ctlw(0, 0, 0, 0, 1, 0, 2'd0);
  endtask

  task automatic t_reject();
    clear_log();
    cfg(0, 0, 20'h05000); cfg(0, 1, 20'h06000); cfg(0, 2, 20'd3);
    ctlw(0, 1, 0, 0, 1, 0, 2'd0);
    ctlw(0, 0, 0, 0, 1, 1, 2'd0);
    chk("R2 rejected write keeps enable", ch_en[0], 1);
    fire(2'b01); idle(10);
    chk("R2 old mode still runs", n_rd, 1);
    chk("R2 destination not stepping", wr_a[0], 20'h06000);
    ctlw(0, 0, 0, 0, 0, 0, 2'd0);
    ctlw(0, 1, 0, 0, 1, 1, 2'd0);
    chk("R2 rejected enable", ch_en[0], 0);
  endtask

  task automatic t_trig();
    clear_log();
    cfg(1, 0, 20'h07000); cfg(1, 1, 20'h08000); cfg(1, 2, 20'd20);
    ctlw(1, 1, 0, 0, 1, 0, 2'd1);
    @(negedge clk); ext_line[1] = 1'b1; idle(10);
    chk("R9 rising ignored in falling mode", n_rd, 0);
    @(negedge clk); ext_line[1] = 1'b0; idle(10);
    chk("R9 falling edge accepted", n_rd, 1);
    ctlw(1, 1, 0, 0, 1, 0, 2'd2);
    @(negedge clk); ext_line[1] = 1'b1; idle(10);
    chk("R9 both mode rising", n_rd, 2);
    @(negedge clk); ext_line[1] = 1'b0; idle(10);
    chk("R9 both mode falling", n_rd, 3);
    ctlw(1, 1, 0, 0, 1, 0, 2'd0);
    @(negedge clk); ext_line[1] = 1'b1; idle(5);
    @(negedge clk); ext_line[1] = 1'b0; idle(10);
    chk("R9 line ignored in software mode", n_rd, 3);
    fire(2'b10); idle(10);
    chk("R9 software pulse", rd_a[3], 20'h07003);
    ctlw(1, 0, 0, 0, 0, 0, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R4 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_single();
    t_wide();
    t_repeat();
    t_priority();
    t_collapse();
    t_reject();
    t_trig();
    idle(5);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule